// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit address pointers and the control register that governs them, for a small microcontroller core. The core reports the end of every pointer-related instruction with a one-cycle strobe and a class code. The block then updates its state: it steps or loads the active pointer, may advance that pointer on its own after a memory move, and may swap which pointer is active. The address the core drives onto its memory bus is always the pointer value visible before the strobe, because every update lands on the clock edge that ends the instruction.

The control register is written through a single byte-wide port and read back on `ctl_rdata`. Bit 0 chooses the active pointer. Bit 4 enables the automatic step after memory moves. Bit 5 enables automatic swapping of the select bit. Bits 6 and 7 set the stepping direction of pointer 0 and pointer 1.

Top module: `dptr_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first write or instruction, both pointers and the control register read as zero on `ptr_out` and `ctl_rdata`.
- R2: A control write stores bits 0, 4, 5, 6 and 7 of `ctl_wdata`. Bits 1 to 3 always read as zero. The new value is visible on `ctl_rdata` the cycle after the write.
- R3: `ptr_out` shows pointer 0 when control bit 0 is 0 and pointer 1 when it is 1.
- R4: Class code 1 (explicit step) moves only the active pointer by one. Control bit 6 sets the direction of pointer 0 and bit 7 sets the direction of pointer 1; 0 counts up and 1 counts down. The other pointer keeps its value.
- R5: Class code 2 (immediate load) writes `load_value` into the active pointer only.
- R6: When control bit 5 is 1, control bit 0 inverts after each of class codes 1, 2, 3 (code read), 4 (external read) and 5 (external write).
- R7: When control bit 4 is 1, class codes 3, 4 and 5 step the active pointer by one in its direction. Code 2 never steps the pointer. Code 1 steps it exactly once.
- R8: With bits 4 and 5 both set, the step goes to the pointer that was active during the instruction, and the select bit inverts in the same cycle.
- R9: Pointer arithmetic wraps modulo 2^16: 0xFFFF counts up to 0x0000 and 0x0000 counts down to 0xFFFF.
- R10: Class codes 0, 6 and 7, and strobe-low cycles, change neither pointer nor the control register.
- R11: When a control write and an instruction strobe fall in the same cycle, the instruction uses the control value from before the write, and the written value wins in the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | A pointer-related instruction finished this cycle |
| op_class | input | 3 | Class of the finished instruction (1 step, 2 load, 3 code read, 4 external read, 5 external write) |
| load_value | input | 16 | Immediate value for class 2 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ptr_out | output | 16 | Value of the active pointer |
| ctl_rdata | output | 8 | Control register readback |

## Verification
The assertions assume that `op_class` is meaningful only while `op_valid` is high. They also assume that strobes and writes arrive as single-cycle pulses that are sampled once per edge, with no further handshake. The bench drives every input at the falling edge, one instruction per cycle at most, and holds its stimulus idle until the internal reset release has finished. Back-to-back strobes, control writes coinciding with strobes, and the reserved class codes are all included on purpose, so the priority and no-effect rules meet the same assertions as ordinary traffic.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_STEP  = 3'd1,
    OPC_LOAD  = 3'd2,
    OPC_CRD   = 3'd3,
    OPC_XRD   = 3'd4,
    OPC_XWR   = 3'd5,
    OPC_RSV6  = 3'd6,
    OPC_RSV7  = 3'd7
  } op_class_e;

  localparam int CTL_W       = 8;
  localparam int BIT_SEL     = 0;
  localparam int BIT_AUTO    = 4;
  localparam int BIT_TGL     = 5;
  localparam int BIT_DIR0    = 6;
  localparam int BIT_DIR1    = 7;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'hF1;

  typedef struct packed {
    logic [1:0] dir;
    logic       tgl_en;
    logic       auto_en;
    logic       sel;
  } ctl_fields_t;

  function automatic logic is_ptr_op(input logic [2:0] c);
    return (c >= OPC_STEP) && (c <= OPC_XWR);
  endfunction

  function automatic logic is_mem_op(input logic [2:0] c);
    return (c == OPC_CRD) || (c == OPC_XRD) || (c == OPC_XWR);
  endfunction

endpackage

// File: rtl/dptr_rst_sync.sv
module dptr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dptr_ctl_reg.sv
module dptr_ctl_reg
  import dptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             toggle_req,
  output ctl_fields_t      fields,
  output logic [CTL_W-1:0] rdata
);

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  always_comb begin
    ctl_en = wr_en | toggle_req;
    ctl_d  = ctl_q;
    if (wr_en) begin
      ctl_d = wr_data & CTL_MASK;
    end else if (toggle_req) begin
      ctl_d[BIT_SEL] = ~ctl_q[BIT_SEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_comb begin
    fields.sel     = ctl_q[BIT_SEL];
    fields.auto_en = ctl_q[BIT_AUTO];
    fields.tgl_en  = ctl_q[BIT_TGL];
    fields.dir     = {ctl_q[BIT_DIR1], ctl_q[BIT_DIR0]};
    rdata          = ctl_q;
  end

  // R2: written value appears masked on the next cycle
  p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wr_data) & CTL_MASK));

  // R6: toggle request without write flips the select bit only
  p_sel_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_req && !wr_en) |=> (rdata[BIT_SEL] != $past(rdata[BIT_SEL]))
                               && (rdata[7:1] == $past(rdata[7:1])));

  // R10: no request keeps the register stable
  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle_req && !wr_en) |=> $stable(rdata));

endmodule

// File: rtl/dptr_ptr_reg.sv
module dptr_ptr_reg #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  input  logic             step_dec,
  output logic [PTR_W-1:0] value
);

  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] ONES = '1;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] stepped;
  logic             ptr_en;

  always_comb begin
    stepped = step_dec ? (ptr_q - ONE) : (ptr_q + ONE);
    ptr_en  = load_en | step_en;
    if (load_en)      ptr_d = load_val;
    else if (step_en) ptr_d = stepped;
    else              ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign value = ptr_q;

  // R5: load takes the immediate
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> value == $past(load_val));

  // R4: count up by one
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !step_dec) |=> value == $past(value) + ONE);

  // R4: count down by one
  p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && step_dec) |=> value == $past(value) - ONE);

  // R9: wrap at the top
  p_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !step_dec && value == ONES) |=> value == '0);

  // R9: wrap at the bottom
  p_wrap_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && step_dec && value == '0) |=> value == ONES);

  // R10: idle keeps the pointer
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(value));

endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int NUM_PTR   = 2,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_class,
  input  logic [PTR_W-1:0] load_value,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [PTR_W-1:0] ptr_out,
  output logic [7:0]       ctl_rdata
);

  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  logic              rst_n_s;
  ctl_fields_t       ctl;
  logic              ptr_op;
  logic              mem_op;
  logic              load_op;
  logic              step_any;
  logic              toggle_req;
  logic [PTR_W-1:0]  ptr_val [NUM_PTR];
  logic [NUM_PTR-1:0] active;

  dptr_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    ptr_op     = op_valid && is_ptr_op(op_class);
    mem_op     = op_valid && is_mem_op(op_class);
    load_op    = op_valid && (op_class == OPC_LOAD);
    step_any   = (op_valid && (op_class == OPC_STEP)) || (mem_op && ctl.auto_en);
    toggle_req = ptr_op && ctl.tgl_en;
  end

  dptr_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (ctl_we),
    .wr_data    (ctl_wdata),
    .toggle_req (toggle_req),
    .fields     (ctl),
    .rdata      (ctl_rdata)
  );

  for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
    assign active[gi] = (SEL_W'(ctl.sel) == SEL_W'(gi));
    dptr_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .load_en  (load_op && active[gi]),
      .load_val (load_value),
      .step_en  (step_any && active[gi]),
      .step_dec (ctl.dir[gi]),
      .value    (ptr_val[gi])
    );
  end

  assign ptr_out = ptr_val[ctl.sel];

  // R4/R7: the inactive pointer never moves
  p_idle_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_rdata[BIT_SEL] == 1'b0) |=> $stable(ptr_val[1]));

  // R7: a load never steps after the write
  p_load_nostep_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (load_op && !ctl_we && !ctl_rdata[BIT_TGL]) |=> ptr_out == $past(load_value));

  // R11: a write coinciding with an instruction wins in the register
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_we && ptr_op) |=> ctl_rdata == ($past(ctl_wdata) & CTL_MASK));

  // R3: select bit picks the visible pointer
  p_view_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    ptr_out == (ctl_rdata[BIT_SEL] ? ptr_val[1] : ptr_val[0]));

endmodule

// File: tb/dptr_unit_tb.sv
module dptr_unit_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_class;
  logic [15:0] load_value;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [15:0] ptr_out;
  logic [7:0]  ctl_rdata;

  int n_checks;
  int n_fail;
  int m_ptr [2];
  int m_ctl;
  bit done;

  dptr_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_class   (op_class),
    .load_value (load_value),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .ptr_out    (ptr_out),
    .ctl_rdata  (ctl_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    int s;
    s = m_ctl & 1;
    check(req, int'(ctl_rdata), m_ctl, "ctl_rdata");
    check(req, int'(ptr_out), m_ptr[s], "ptr_out");
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge(input bit v, input int c, input int ld, input bit we, input int wd);
    int  s;
    bit  pop;
    bit  stp;
    s   = m_ctl & 1;
    pop = v && (c >= 1) && (c <= 5);
    stp = v && ((c == 1) || ((c >= 3) && (c <= 5) && ((m_ctl >> 4) & 1) == 1));
    if (v && c == 2) m_ptr[s] = ld & 16'hFFFF;
    else if (stp) begin
      if (((m_ctl >> (6 + s)) & 1) == 1) m_ptr[s] = (m_ptr[s] - 1) & 16'hFFFF;
      else                               m_ptr[s] = (m_ptr[s] + 1) & 16'hFFFF;
    end
    if (we) m_ctl = wd & 8'hF1;
    else if (pop && ((m_ctl >> 5) & 1) == 1) m_ctl = m_ctl ^ 1;
  endtask

  task automatic cyc(input string req, input bit v, input int c, input int ld,
                     input bit we, input int wd);
    op_valid   = v;
    op_class   = 3'(c);
    load_value = 16'(ld);
    ctl_we     = we;
    ctl_wdata  = 8'(wd);
    @(posedge clk);
    model_edge(v, c, ld, we, wd);
    @(negedge clk);
    op_valid = 1'b0;
    ctl_we   = 1'b0;
    compare(req);
  endtask

  task automatic wr(input string req, input int wd);
    cyc(req, 1'b0, 0, 0, 1'b1, wd);
  endtask

  task automatic op(input string req, input int c, input int ld);
    cyc(req, 1'b1, c, ld, 1'b0, 0);
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (!done && cnt < WATCHDOG) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cnt, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    m_ptr[0] = 0; m_ptr[1] = 0; m_ctl = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_class = '0; load_value = '0;
    ctl_we = 1'b0; ctl_wdata = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2: write all ones, reserved bits read zero
    wr("R2", 8'hFF);
    wr("R2", 8'h0E);
    wr("R2", 8'h00);

    // R5: load pointer 0, then pointer 1
    op("R5", 2, 16'h1234);
    wr("R3", 8'h01);
    op("R5", 2, 16'hABCD);
    wr("R3", 8'h00);
    // R4: step pointer 0 up, pointer 1 untouched
    op("R4", 1, 0);
    op("R4", 1, 0);
    wr("R4", 8'h01);
    wr("R4", 8'h81);
    op("R4", 1, 0);
    // R4: pointer 0 counts down with bit 6
    wr("R4", 8'h40);
    op("R4", 1, 0);
    // R9: wrap both ways
    op("R9", 2, 16'h0000);
    op("R9", 1, 0);
    wr("R9", 8'h00);
    op("R9", 1, 0);
    // R10: reserved codes and memory ops without auto
    op("R10", 0, 0);
    op("R10", 6, 16'h5555);
    op("R10", 7, 16'h5555);
    op("R10", 3, 0);
    op("R10", 4, 0);
    op("R10", 5, 0);
    // R7: auto step on memory ops, never on load, once on step
    wr("R7", 8'h10);
    op("R7", 3, 0);
    op("R7", 4, 0);
    op("R7", 5, 0);
    op("R7", 2, 16'h0100);
    op("R7", 1, 0);
    // R6: toggle on each of the five classes
    wr("R6", 8'h20);
    for (int k = 1; k <= 5; k++) op("R6", k, 16'h0F00 + k);
    op("R6", 6, 0);
    // R8: both enabled, pointer 1 counting down
    wr("R8", 8'hB1);
    op("R8", 3, 0);
    op("R8", 4, 0);
    op("R8", 5, 0);
    // R11: write and instruction in the same cycle
    cyc("R11", 1'b1, 1, 0, 1'b1, 8'h01);
    cyc("R11", 1'b1, 2, 16'h7777, 1'b1, 8'h30);
    cyc("R11", 1'b1, 4, 0, 1'b1, 8'hF1);

    // R3: mixed traffic
    for (int i = 0; i < 400; i++) begin
      int  r;
      bit  v;
      bit  we;
      r  = int'($urandom_range(0, 99));
      v  = (r < 70);
      we = (r >= 60 && r < 80);
      cyc("R3", v, int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
          we, int'($urandom_range(0, 255)));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule